// File: doc/BRIEF.md
# Two-Dimensional Video Memory DMA Engine

This block moves bytes inside a byte-wide video memory without the CPU doing the work. Software programs a bank of sixteen byte-wide registers with a source offset, a destination offset, a transfer size and two row strides, then sets a start bit. The engine can run a linear copy, a rectangular copy with separate source and destination row pitches, or a fill that writes one programmed byte over a destination region. It owns a single synchronous memory port. A read issued in one cycle returns its data in the next.

Before a transfer starts, the engine checks the programmed size and the address span against the configured memory size. A bad request raises one or more error flags and leaves memory untouched. While a transfer runs, the busy flag is set and CPU requests to the video memory are refused. The same register offset is used in two ways: a write to it sets the fill byte, and a read from it returns status.

Top module: `vdma_engine`

## Requirements
- R1: Register offsets are fixed as follows. Offset 0 is control: bit 0 enable, bit 1 rectangular mode, bit 2 fill mode, bit 7 start. Offset 1 reads status and a write to it sets the fill byte. Offsets 2..4 hold the source offset and 5..7 the destination offset, each least significant byte first. Offsets 8..11 hold the size, 12..13 the source stride and 14..15 the destination stride. Every byte at offsets 2..15 reads back as written, and bit 7 of control always reads 0.
- R2: In linear mode, size bytes 8..10 form a 24-bit count, and that many bytes are copied from the source to the destination in ascending address order.
- R3: In rectangular mode, bytes 8..9 are the width and 10..11 the height. Each row start advances by the source stride on the read side and by the destination stride on the write side. A copy spends two cycles per byte: a read, then a write of the returned data.
- R4: In fill mode, the fill byte is written to every destination byte at one byte per cycle. No memory read is issued, and the source offset and source stride are ignored. A write to offset 1 does not change the status value read there.
- R5: Status bit 7 is 1 from the cycle after an accepted start up to and including the cycle of the final write, and 0 in the cycle after it.
- R6: A CPU memory request is granted and reaches the memory only while status bit 7 is 0. A refused CPU write leaves memory unchanged.
- R7: Status bit 0 is set and no transfer runs when the linear count is 0, or in rectangular mode when the width or height is 0, the destination stride is below the width, or (copy only) the source stride is below the width.
- R8: Status bit 1 is set and no transfer runs when the last destination byte would lie at or beyond the configured memory size. A region that ends exactly at the memory size is accepted.
- R9: Status bit 2 is set and no transfer runs when a copy's last source byte would lie at or beyond the memory size. This check is not made in fill mode.
- R10: Each accepted start replaces all three error flags with its own result. The address checks in R8 and R9 are only made when the size is valid.
- R11: A start is accepted only when the same control write also sets enable and no transfer is running. Any other start changes neither status nor memory.
- R12: After reset, status, control and all configuration bytes read 0 and the memory port is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| cpu_mem_req | input | 1 | CPU request to video memory |
| cpu_mem_we | input | 1 | CPU request is a write |
| cpu_mem_addr | input | 24 | CPU memory offset |
| cpu_mem_wdata | input | 8 | CPU write data |
| cpu_mem_gnt | output | 1 | CPU request reaches memory this cycle |
| cpu_mem_rdata | output | 8 | Read data returned to the CPU |
| mem_en | output | 1 | Memory port enable |
| mem_we | output | 1 | Memory port write |
| mem_addr | output | 24 | Memory port offset |
| mem_wdata | output | 8 | Memory port write data |
| mem_rdata | input | 8 | Memory read data, one cycle after the read |

## Verification
The hardest case to reach is a start write that arrives while a transfer is still running. The control write has to land in the middle of a multi-cycle rectangular copy, and its mode bits differ from those of the running job. The bench issues that write a few cycles into a copy. It then checks that the write stream still matches the original job exactly, with no extra writes and no fill bytes. A second hard case is a CPU write that targets a source byte still to be copied while the lockout is active. The bench checks that the copied data reflects the original contents.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
    localparam int AW = 24;

    // register offsets whose position the bench and software rely on
    localparam logic [3:0] OFF_CTRL = 4'd0;
    localparam logic [3:0] OFF_STAT = 4'd1;

    localparam int CB_EN   = 0;
    localparam int CB_2D   = 1;
    localparam int CB_FILL = 2;
    localparam int CB_GO   = 7;

    localparam int EB_SIZE = 0;
    localparam int EB_DST  = 1;
    localparam int EB_SRC  = 2;

    typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} walk_st_e;

    typedef struct packed {
        logic enable;
        logic two_d;
        logic fill;
    } ctrl_t;

    typedef struct packed {
        ctrl_t          ctrl;
        logic [AW-1:0]  src;
        logic [AW-1:0]  dst;
        logic [31:0]    size;
        logic [15:0]    sstride;
        logic [15:0]    dstride;
        logic [7:0]     fill_byte;
    } cfg_t;

    typedef struct packed {
        walk_st_e       st;
        logic           fill;
        logic [AW-1:0]  src_row;
        logic [AW-1:0]  dst_row;
        logic [AW-1:0]  src_ptr;
        logic [AW-1:0]  dst_ptr;
        logic [AW-1:0]  col;
        logic [AW-1:0]  width;
        logic [15:0]    row;
        logic [15:0]    height;
        logic [15:0]    sstr;
        logic [15:0]    dstr;
        logic [7:0]     fbyte;
        logic [2:0]     err;
    } walk_t;
endpackage

// File: rtl/vdma_regs.sv
module vdma_regs
    import vdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we_i,
    input  logic [3:0]  sel_i,
    input  logic [7:0]  wdata_i,
    input  logic [7:0]  status_i,
    output logic [7:0]  rdata_o,
    output cfg_t        cfg_o,
    output logic        start_o
);
    localparam int NREG = 16;

    logic [NREG-1:0][7:0] bank_d, bank_q;
    logic                 ctrl_wr;

    assign ctrl_wr = we_i && (sel_i == OFF_CTRL);

    always_comb begin
        bank_d = bank_q;
        if (we_i) begin
            if (sel_i == OFF_CTRL) begin
                bank_d[OFF_CTRL] = {1'b0, wdata_i[6:0]};
            end else begin
                bank_d[sel_i] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    always_comb begin
        case (sel_i)
            OFF_CTRL: rdata_o = bank_q[OFF_CTRL];
            OFF_STAT: rdata_o = status_i;
            default:  rdata_o = bank_q[sel_i];
        endcase
    end

    // a control write forwards its own mode bits to the start decision
    always_comb begin
        if (ctrl_wr) begin
            cfg_o.ctrl = '{enable: wdata_i[CB_EN], two_d: wdata_i[CB_2D], fill: wdata_i[CB_FILL]};
        end else begin
            cfg_o.ctrl = '{enable: bank_q[OFF_CTRL][CB_EN], two_d: bank_q[OFF_CTRL][CB_2D],
                           fill: bank_q[OFF_CTRL][CB_FILL]};
        end
        cfg_o.src       = {bank_q[4], bank_q[3], bank_q[2]};
        cfg_o.dst       = {bank_q[7], bank_q[6], bank_q[5]};
        cfg_o.size      = {bank_q[11], bank_q[10], bank_q[9], bank_q[8]};
        cfg_o.sstride   = {bank_q[13], bank_q[12]};
        cfg_o.dstride   = {bank_q[15], bank_q[14]};
        cfg_o.fill_byte = bank_q[OFF_STAT];
    end

    assign start_o = ctrl_wr && wdata_i[CB_GO] && wdata_i[CB_EN];

    // R1
    ctrl_go_never_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (bank_q[OFF_CTRL][7] == 1'b0));
endmodule

// File: rtl/vdma_check.sv
module vdma_check
    import vdma_pkg::*;
#(
    parameter int MEM_SIZE = 1024
)(
    input  cfg_t        cfg_i,
    output logic [2:0]  err_o
);
    localparam int        XW    = 34;
    localparam logic [XW-1:0] LIMIT = XW'(MEM_SIZE);

    logic [XW-1:0] w_x, h_x, s_end, d_end;
    logic          size_bad;

    always_comb begin
        if (cfg_i.ctrl.two_d) begin
            w_x = {18'b0, cfg_i.size[15:0]};
            h_x = {18'b0, cfg_i.size[31:16]};
            size_bad = (w_x == '0) || (h_x == '0)
                     || ({18'b0, cfg_i.dstride} < w_x)
                     || (!cfg_i.ctrl.fill && ({18'b0, cfg_i.sstride} < w_x));
            s_end = XW'(cfg_i.src) + (h_x - XW'(1)) * {18'b0, cfg_i.sstride} + w_x;
            d_end = XW'(cfg_i.dst) + (h_x - XW'(1)) * {18'b0, cfg_i.dstride} + w_x;
        end else begin
            w_x = {10'b0, cfg_i.size[23:0]};
            h_x = XW'(1);
            size_bad = (w_x == '0);
            s_end = XW'(cfg_i.src) + w_x;
            d_end = XW'(cfg_i.dst) + w_x;
        end
        err_o = '0;
        err_o[EB_SIZE] = size_bad;
        err_o[EB_DST]  = !size_bad && (d_end > LIMIT);
        err_o[EB_SRC]  = !size_bad && !cfg_i.ctrl.fill && (s_end > LIMIT);
    end
endmodule

// File: rtl/vdma_walk.sv
module vdma_walk
    import vdma_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  cfg_t           cfg_i,
    input  logic [2:0]     err_i,
    input  logic [7:0]     mem_rdata_i,
    output logic           busy_o,
    output logic [2:0]     err_o,
    output logic           eng_en_o,
    output logic           eng_we_o,
    output logic [AW-1:0]  eng_addr_o,
    output logic [7:0]     eng_wdata_o
);
    walk_t    q, d;
    walk_st_e next_byte_st;
    logic     last_col, last_row;

    assign last_col     = (q.col == q.width - AW'(1));
    assign last_row     = (q.row == q.height - 16'd1);
    assign next_byte_st = q.fill ? ST_WR : ST_RD;

    always_comb begin
        d           = q;
        eng_en_o    = 1'b0;
        eng_we_o    = 1'b0;
        eng_addr_o  = q.src_ptr;
        eng_wdata_o = q.fbyte;
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.err = err_i;
                    if (err_i == 3'b000) begin
                        d.fill    = cfg_i.ctrl.fill;
                        d.src_row = cfg_i.src;
                        d.src_ptr = cfg_i.src;
                        d.dst_row = cfg_i.dst;
                        d.dst_ptr = cfg_i.dst;
                        d.col     = '0;
                        d.row     = '0;
                        d.sstr    = cfg_i.sstride;
                        d.dstr    = cfg_i.dstride;
                        d.fbyte   = cfg_i.fill_byte;
                        if (cfg_i.ctrl.two_d) begin
                            d.width  = {8'b0, cfg_i.size[15:0]};
                            d.height = cfg_i.size[31:16];
                        end else begin
                            d.width  = cfg_i.size[23:0];
                            d.height = 16'd1;
                        end
                        d.st = cfg_i.ctrl.fill ? ST_WR : ST_RD;
                    end
                end
            end
            ST_RD: begin
                eng_en_o   = 1'b1;
                eng_addr_o = q.src_ptr;
                d.st       = ST_WR;
            end
            ST_WR: begin
                eng_en_o    = 1'b1;
                eng_we_o    = 1'b1;
                eng_addr_o  = q.dst_ptr;
                eng_wdata_o = q.fill ? q.fbyte : mem_rdata_i;
                if (last_col) begin
                    d.col = '0;
                    if (last_row) begin
                        d.st = ST_IDLE;
                    end else begin
                        d.row     = q.row + 16'd1;
                        d.src_row = q.src_row + {8'b0, q.sstr};
                        d.dst_row = q.dst_row + {8'b0, q.dstr};
                        d.src_ptr = q.src_row + {8'b0, q.sstr};
                        d.dst_ptr = q.dst_row + {8'b0, q.dstr};
                        d.st      = next_byte_st;
                    end
                end else begin
                    d.col     = q.col + AW'(1);
                    d.src_ptr = q.src_ptr + AW'(1);
                    d.dst_ptr = q.dst_ptr + AW'(1);
                    d.st      = next_byte_st;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy_o = (q.st != ST_IDLE);
    assign err_o  = q.err;

    // R5
    last_write_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WR && last_col && last_row) |=> !busy_o);

    // R7
    err_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && start_i && err_i != 3'b000) |=> (!busy_o && q.err == $past(err_i)));

    // R3
    copy_read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WR && !q.fill) |-> ($past(q.st) == ST_RD));

    // R4
    fill_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && q.fill) |-> (q.st == ST_WR));
endmodule

// File: rtl/vdma_engine.sv
module vdma_engine
    import vdma_pkg::*;
#(
    parameter int MEM_SIZE = 1024
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_we,
    input  logic [3:0]   reg_sel,
    input  logic [7:0]   reg_wdata,
    output logic [7:0]   reg_rdata,
    input  logic         cpu_mem_req,
    input  logic         cpu_mem_we,
    input  logic [23:0]  cpu_mem_addr,
    input  logic [7:0]   cpu_mem_wdata,
    output logic         cpu_mem_gnt,
    output logic [7:0]   cpu_mem_rdata,
    output logic         mem_en,
    output logic         mem_we,
    output logic [23:0]  mem_addr,
    output logic [7:0]   mem_wdata,
    input  logic [7:0]   mem_rdata
);
    cfg_t           cfg;
    logic           start;
    logic [2:0]     chk_err, err_q;
    logic           busy;
    logic [7:0]     status;
    logic           eng_en, eng_we;
    logic [AW-1:0]  eng_addr;
    logic [7:0]     eng_wdata;

    assign status = {busy, 4'b0000, err_q};

    vdma_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (reg_we),
        .sel_i    (reg_sel),
        .wdata_i  (reg_wdata),
        .status_i (status),
        .rdata_o  (reg_rdata),
        .cfg_o    (cfg),
        .start_o  (start)
    );

    vdma_check #(.MEM_SIZE(MEM_SIZE)) u_check (
        .cfg_i (cfg),
        .err_o (chk_err)
    );

    vdma_walk u_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .cfg_i       (cfg),
        .err_i       (chk_err),
        .mem_rdata_i (mem_rdata),
        .busy_o      (busy),
        .err_o       (err_q),
        .eng_en_o    (eng_en),
        .eng_we_o    (eng_we),
        .eng_addr_o  (eng_addr),
        .eng_wdata_o (eng_wdata)
    );

    always_comb begin
        if (busy) begin
            mem_en    = eng_en;
            mem_we    = eng_we;
            mem_addr  = eng_addr;
            mem_wdata = eng_wdata;
        end else begin
            mem_en    = cpu_mem_req;
            mem_we    = cpu_mem_req && cpu_mem_we;
            mem_addr  = cpu_mem_addr;
            mem_wdata = cpu_mem_wdata;
        end
    end

    assign cpu_mem_gnt   = cpu_mem_req && !busy;
    assign cpu_mem_rdata = mem_rdata;

    // R8
    engine_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_en) |-> (mem_addr < AW'(MEM_SIZE)));

    // R6
    lockout_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_we) |-> (mem_wdata == eng_wdata && !cpu_mem_gnt));
endmodule

// File: tb/tb_vdma_engine.sv
`timescale 1ns/1ps
module tb_vdma_engine;
    localparam int MEM = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_sel = 4'd1;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        cpu_mem_req = 1'b0;
    logic        cpu_mem_we = 1'b0;
    logic [23:0] cpu_mem_addr = '0;
    logic [7:0]  cpu_mem_wdata = '0;
    logic        cpu_mem_gnt;
    logic [7:0]  cpu_mem_rdata;
    logic        mem_en, mem_we;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;

    always #2 clk = ~clk;

    vdma_engine #(.MEM_SIZE(MEM)) dut (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cpu_mem_req(cpu_mem_req), .cpu_mem_we(cpu_mem_we), .cpu_mem_addr(cpu_mem_addr),
        .cpu_mem_wdata(cpu_mem_wdata), .cpu_mem_gnt(cpu_mem_gnt), .cpu_mem_rdata(cpu_mem_rdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    logic [7:0] vmem [MEM];
    logic [7:0] refm [MEM];
    logic [7:0] rd_q = 8'h00;

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) vmem[mem_addr[9:0]] <= mem_wdata;
            else        rd_q <= vmem[mem_addr[9:0]];
        end
    end
    assign mem_rdata = rd_q;

    int          n_chk = 0;
    int          n_bad = 0;
    int          remain = 0;
    logic        fill_mode = 1'b0;
    logic        mon_on = 1'b0;
    logic [23:0] qa[$];
    logic [7:0]  qd[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // reference model, compared every cycle
    always @(negedge clk) begin
        if (mon_on) begin
            if (reg_sel == 4'd1 && !reg_we)
                chk(reg_rdata[7] == (remain > 0), "R5 busy flag", int'(reg_rdata[7]), int'(remain > 0));
            if (mem_en && mem_we) begin
                if (remain > 0) begin
                    if (qa.size() == 0) begin
                        chk(1'b0, "R2 surplus engine write", int'(mem_addr), 0);
                    end else begin
                        chk(mem_addr == qa[0] && mem_wdata == qd[0], "R3 write stream",
                            int'({mem_addr, mem_wdata}), int'({qa[0], qd[0]}));
                        void'(qa.pop_front());
                        void'(qd.pop_front());
                    end
                end else if (!cpu_mem_req) begin
                    chk(1'b0, "R11 unexpected write", int'(mem_addr), 0);
                end
            end
            if (remain > 0 && fill_mode && mem_en && !mem_we)
                chk(1'b0, "R4 read during fill", int'(mem_addr), 0);
            if (remain > 0) remain--;
        end
    end

    task automatic wreg(input logic [3:0] off, input logic [7:0] val);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_sel = off; reg_wdata = val;
        @(posedge clk); #1;
        reg_we = 1'b0; reg_sel = 4'd1;
    endtask

    task automatic rreg(input logic [3:0] off, output logic [7:0] val);
        @(posedge clk); #1;
        reg_sel = off;
        @(negedge clk);
        val = reg_rdata;
        @(posedge clk); #1;
        reg_sel = 4'd1;
    endtask

    task automatic kick(input logic [7:0] ctrl, input int cyc);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_sel = 4'd0; reg_wdata = ctrl;
        @(posedge clk); #1;
        reg_we = 1'b0; reg_sel = 4'd1;
        remain = cyc;
    endtask

    task automatic setup(input int src, input int dst, input logic [31:0] size,
                         input int ss, input int ds);
        wreg(4'd2, src[7:0]);   wreg(4'd3, src[15:8]);  wreg(4'd4, src[23:16]);
        wreg(4'd5, dst[7:0]);   wreg(4'd6, dst[15:8]);  wreg(4'd7, dst[23:16]);
        wreg(4'd8, size[7:0]);  wreg(4'd9, size[15:8]);
        wreg(4'd10, size[23:16]); wreg(4'd11, size[31:24]);
        wreg(4'd12, ss[7:0]);   wreg(4'd13, ss[15:8]);
        wreg(4'd14, ds[7:0]);   wreg(4'd15, ds[15:8]);
    endtask

    // expected writes derived from the requirements; returns busy cycles
    task automatic plan(input bit fill, input int src, input int dst, input int w, input int h,
                        input int ss, input int ds, input logic [7:0] fb, output int cyc);
        for (int r = 0; r < h; r++) begin
            for (int c = 0; c < w; c++) begin
                int a;
                logic [7:0] v;
                a = dst + r * ds + c;
                v = fill ? fb : refm[src + r * ss + c];
                qa.push_back(24'(a));
                qd.push_back(v);
                refm[a] = v;
            end
        end
        fill_mode = fill;
        cyc = w * h * (fill ? 1 : 2);
    endtask

    task automatic wait_done();
        while (remain > 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic mem_cmp(input string req);
        int bad;
        bad = 0;
        for (int i = 0; i < MEM; i++) if (vmem[i] !== refm[i]) bad++;
        chk(bad == 0 && qa.size() == 0, req, bad + qa.size(), 0);
    endtask

    task automatic finish_up();
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #600000;
        chk(1'b0, "watchdog expired", 0, 1);
        finish_up();
    end

    initial begin
        logic [7:0] v;
        int cyc;
        for (int i = 0; i < MEM; i++) begin
            vmem[i] = 8'(i * 7 + 3);
            refm[i] = 8'(i * 7 + 3);
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(mem_en == 1'b0, "R12 memory port idle", int'(mem_en), 0);
        mon_on = 1'b1;

        rreg(4'd1, v); chk(v == 8'h00, "R12 status after reset", v, 0);
        rreg(4'd0, v); chk(v == 8'h00, "R12 control after reset", v, 0);
        rreg(4'd9, v); chk(v == 8'h00, "R12 size byte after reset", v, 0);

        // R1 byte order and readback
        setup(24'h123456, 0, 32'hA1B2C3D4, 16'h0E0F, 16'h0A0B);
        rreg(4'd2, v); chk(v == 8'h56, "R1 source low", v, 8'h56);
        rreg(4'd4, v); chk(v == 8'h12, "R1 source high", v, 8'h12);
        rreg(4'd11, v); chk(v == 8'hA1, "R1 size top", v, 8'hA1);
        rreg(4'd14, v); chk(v == 8'h0B, "R1 dest stride low", v, 8'h0B);

        // R6 idle CPU write goes through
        @(posedge clk); #1;
        cpu_mem_req = 1'b1; cpu_mem_we = 1'b1; cpu_mem_addr = 24'd6; cpu_mem_wdata = 8'h5A;
        @(negedge clk);
        chk(cpu_mem_gnt == 1'b1, "R6 grant when idle", int'(cpu_mem_gnt), 1);
        @(posedge clk); #1;
        cpu_mem_req = 1'b0; cpu_mem_we = 1'b0;
        refm[6] = 8'h5A;

        // R2 linear copy spanning several size bytes
        setup(0, 400, 300, 0, 0);
        plan(1'b0, 0, 400, 300, 1, 0, 0, 8'h00, cyc);
        kick(8'h81, cyc);
        wait_done();
        mem_cmp("R2 linear copy result");
        rreg(4'd0, v); chk(v == 8'h01, "R1 start bit reads 0", v, 8'h01);

        // R3 rectangular copy, unequal strides; R11 start during busy
        setup(100, 600, {16'd4, 16'd5}, 8, 12);
        plan(1'b0, 100, 600, 5, 4, 8, 12, 8'h00, cyc);
        kick(8'h83, cyc);
        repeat (4) @(negedge clk);
        wreg(4'd0, 8'h85);
        wait_done();
        mem_cmp("R11 start during busy ignored / R3 rect copy");
        rreg(4'd1, v); chk(v == 8'h00, "R3 status after rect copy", v, 0);

        // R4 fill byte via offset 1, status unaffected
        wreg(4'd1, 8'hA5);
        rreg(4'd1, v); chk(v == 8'h00, "R4 fill byte write leaves status", v, 0);
        setup(24'hFFFFFF, 300, {16'd3, 16'd6}, 1, 10);
        plan(1'b1, 0, 300, 6, 3, 0, 10, 8'hA5, cyc);
        kick(8'h87, cyc);
        wait_done();
        mem_cmp("R4 rectangular fill");
        rreg(4'd1, v); chk(v == 8'h00, "R9 fill ignores source", v, 0);

        // R6 lockout during a copy
        setup(0, 700, 30, 0, 0);
        plan(1'b0, 0, 700, 30, 1, 0, 0, 8'h00, cyc);
        kick(8'h81, cyc);
        @(posedge clk); #1;
        cpu_mem_req = 1'b1; cpu_mem_we = 1'b1; cpu_mem_addr = 24'd5; cpu_mem_wdata = 8'hEE;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(cpu_mem_gnt == 1'b0, "R6 no grant while busy", int'(cpu_mem_gnt), 0);
        end
        @(posedge clk); #1;
        cpu_mem_req = 1'b0; cpu_mem_we = 1'b0;
        wait_done();
        mem_cmp("R6 refused CPU write had no effect");

        // R7 size errors
        setup(0, 0, 0, 0, 0);
        kick(8'h81, 0); rreg(4'd1, v); chk(v == 8'h01, "R7 zero linear count", v, 8'h01);
        setup(0, 0, {16'd3, 16'd0}, 4, 4);
        kick(8'h83, 0); rreg(4'd1, v); chk(v == 8'h01, "R7 zero width", v, 8'h01);
        setup(0, 200, {16'd2, 16'd8}, 4, 8);
        kick(8'h83, 0); rreg(4'd1, v); chk(v == 8'h01, "R7 stride below width", v, 8'h01);

        // R10 valid start clears errors; R8 exact end accepted
        setup(50, 1014, 10, 0, 0);
        plan(1'b0, 50, 1014, 10, 1, 0, 0, 8'h00, cyc);
        kick(8'h81, cyc);
        wait_done();
        rreg(4'd1, v); chk(v == 8'h00, "R10 errors cleared by next start", v, 0);
        mem_cmp("R8 region ending at memory size");

        // R8 destination errors
        setup(0, 1020, 10, 0, 0);
        kick(8'h81, 0); rreg(4'd1, v); chk(v == 8'h02, "R8 linear dest overflow", v, 8'h02);
        setup(0, 900, {16'd3, 16'd4}, 4, 100);
        kick(8'h83, 0); rreg(4'd1, v); chk(v == 8'h02, "R8 rect dest overflow", v, 8'h02);

        // R9 source errors
        setup(1000, 0, 40, 0, 0);
        kick(8'h81, 0); rreg(4'd1, v); chk(v == 8'h04, "R9 source overflow", v, 8'h04);
        setup(1000, 1020, 40, 0, 0);
        kick(8'h81, 0); rreg(4'd1, v); chk(v == 8'h06, "R9 both address errors", v, 8'h06);

        // R11 start without enable leaves status
        kick(8'h80, 0);
        repeat (3) @(negedge clk);
        rreg(4'd1, v); chk(v == 8'h06, "R11 disabled start ignored", v, 8'h06);

        // R10 address checks skipped when size invalid
        setup(2000, 3000, 0, 0, 0);
        kick(8'h81, 0); rreg(4'd1, v); chk(v == 8'h01, "R10 size error alone", v, 8'h01);

        // R4 linear fill with out-of-range source
        wreg(4'd1, 8'h3C);
        setup(24'hFFFFFF, 10, 4, 0, 0);
        plan(1'b1, 0, 10, 4, 1, 0, 0, 8'h3C, cyc);
        kick(8'h85, cyc);
        wait_done();
        mem_cmp("R4 linear fill");
        rreg(4'd1, v); chk(v == 8'h00, "R10 fill start cleared errors", v, 0);

        repeat (4) @(negedge clk);
        finish_up();
    end
endmodule